// File: doc/BRIEF.md
# Banked Program Counter Unit

This block holds the 12-bit program address of a small 8-bit controller whose code space is split into two 2K-word halves. The instruction decoder drives one-cycle pulses into it: step forward, jump, call, return, return-from-interrupt, choose the upper or lower half, and interrupt entry. It answers with the address of the next fetch. The 11-bit offset inside a half changes freely. The half-select bit (bit 11) changes only when a jump or call copies it from a pending-half flip-flop. While an interrupt handler runs, that bit is held low.

Calls and interrupt entries save the whole 12-bit address on an internal circular stack of eight entries. Each saved entry also records whether a handler was already running. Return-from-interrupt restores that record and so releases the hold on bit 11. There is no data stream here, only decode pulses and one address output, so every pin is a plain control or status signal and none has a handshake. Each decoder pulse acts for exactly the cycle in which it is high.

Top module: `pc_bank_unit`

## Requirements
- R1: While `rst_n` is low, `pc_o` is 000h. Reset also clears the pending-half flip-flop and the in-handler state, so a jump after reset lands in the lower half even if the upper half was chosen, or a handler was running, before reset.
- R2: A step pulse adds one to bits 10:0 of `pc_o`. The offset wraps from 7FFh to 000h, and bit 11 keeps its value.
- R3: `sel_bank1_i` sets the pending-half flip-flop and `sel_bank0_i` clears it. If both are high, the flip-flop is set. Selecting a half alone leaves `pc_o` unchanged.
- R4: A jump or call loads `pc_o` with {pending-half flip-flop, `target_i`}. The flip-flop value used is the one held before that cycle, so a select in the same cycle only affects later branches.
- R5: A call saves the current 12-bit `pc_o`. A return reloads all 12 bits from the most recent saved entry and leaves the pending-half flip-flop unchanged.
- R6: Interrupt entry saves the current `pc_o`, loads 003h when `irq_vec_i` is 0 or 007h when it is 1, and marks a handler as running.
- R7: While a handler runs, bit 11 of `pc_o` stays 0 after jumps, calls and returns. A half-select in that time changes only the flip-flop.
- R8: Return-from-interrupt reloads the saved address and the saved in-handler state. After returning to code outside a handler, jumps again take bit 11 from the flip-flop.
- R9: The stack holds 8 entries and its pointer wraps. A ninth call overwrites the oldest entry. After nine calls, nine returns yield the entries of calls nine down to two, then the entry of call nine again.
- R10: If several pulses are high together, one operation takes effect, chosen in this order: interrupt entry, call, jump, return-from-interrupt, return, step. Half-select pulses always act in addition to it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| inc_i | input | 1 | Step to the next offset |
| jump_i | input | 1 | Jump to `target_i` |
| call_i | input | 1 | Save address, then jump to `target_i` |
| ret_i | input | 1 | Return from subroutine |
| retr_i | input | 1 | Return from interrupt handler |
| sel_bank0_i | input | 1 | Choose lower half for the next branch |
| sel_bank1_i | input | 1 | Choose upper half for the next branch |
| irq_i | input | 1 | Interrupt entry |
| irq_vec_i | input | 1 | Vector choice: 0 gives 003h, 1 gives 007h |
| target_i | input | 11 | Branch offset inside a half |
| pc_o | output | 12 | Current program address |

## Verification
Every operation is registered once, so its effect on `pc_o` shows one rising edge after the edge that samples the pulse. The pending-half flip-flop and the in-handler state cannot be seen directly. They show up at `pc_o` only after the next branch, one cycle after that branch is sampled. The bench drives pulses on the falling edge and compares `pc_o` at the following falling edge, after exactly one rising edge. It reads the hidden state only through a later jump. The stack-wrap case is checked against the order of the nine calls, not against the pointer.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
  typedef enum logic [2:0] {
    OP_HOLD, OP_INC, OP_JUMP, OP_CALL, OP_RET, OP_RETR, OP_IRQ
  } pc_op_e;

  // Fixed precedence when decode pulses overlap.
  function automatic pc_op_e pick_op(input logic irq, input logic call,
                                     input logic jump, input logic retr,
                                     input logic ret, input logic inc);
    if (irq)       return OP_IRQ;
    else if (call) return OP_CALL;
    else if (jump) return OP_JUMP;
    else if (retr) return OP_RETR;
    else if (ret)  return OP_RET;
    else if (inc)  return OP_INC;
    else           return OP_HOLD;
  endfunction
endpackage

// File: rtl/pcu_bank_ctl.sv
module pcu_bank_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic sel0,
  input  logic sel1,
  input  logic enter,
  input  logic leave,
  input  logic restore_svc,
  output logic bank_ff,
  output logic in_svc
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bank_ff <= 1'b0;
      in_svc  <= 1'b0;
    end else begin
      if (sel1)      bank_ff <= 1'b1;
      else if (sel0) bank_ff <= 1'b0;
      if (enter)      in_svc <= 1'b1;
      else if (leave) in_svc <= restore_svc;
    end
  end

  // R3
  bank_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel1 |=> bank_ff);
  // R3
  bank_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel0 && !sel1) |=> !bank_ff);
  // R5
  bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel0 && !sel1) |=> $stable(bank_ff));
  // R6
  svc_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enter |=> in_svc);
endmodule

// File: rtl/pcu_ret_stack.sv
module pcu_ret_stack #(
  parameter int DEPTH = 8,
  parameter int W     = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] top
);
  localparam int SP_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]    mem [DEPTH];
  logic [SP_W-1:0] sp;
  logic [SP_W-1:0] sp_dec;

  // Power-of-two depth wraps by overflow; otherwise wrap explicitly.
  generate
    if ((1 << SP_W) == DEPTH) begin : g_pow2
      assign sp_dec = sp - 1'b1;
    end else begin : g_any
      assign sp_dec = (sp == '0) ? SP_W'(DEPTH - 1) : sp - 1'b1;
    end
  endgenerate

  assign top = mem[sp_dec];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (push) begin
      mem[sp] <= wdata;
      sp      <= (sp == SP_W'(DEPTH - 1)) ? '0 : sp + 1'b1;
    end else if (pop) begin
      sp <= sp_dec;
    end
  end

  // R9
  push_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> top == $past(wdata));
endmodule

// File: rtl/pcu_pc_reg.sv
module pcu_pc_reg
  import pcu_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int VEC_LO = 3,
  parameter int VEC_HI = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  pc_op_e            op,
  input  logic              vec_sel,
  input  logic [ADDR_W-2:0] target,
  input  logic              bank_ff,
  input  logic              in_svc,
  input  logic [ADDR_W-1:0] pop_addr,
  output logic [ADDR_W-1:0] pc
);
  localparam int MSB = ADDR_W - 1;

  logic [ADDR_W-1:0] pc_nxt;
  logic [MSB-1:0]    ofs_inc;

  assign ofs_inc = pc[MSB-1:0] + 1'b1;

  always_comb begin
    pc_nxt = pc;
    unique case (op)
      OP_INC:          pc_nxt = {pc[MSB], ofs_inc};
      OP_JUMP,
      OP_CALL:         pc_nxt = {bank_ff & ~in_svc, target};
      OP_RET:          pc_nxt = {pop_addr[MSB] & ~in_svc, pop_addr[MSB-1:0]};
      OP_RETR:         pc_nxt = pop_addr;
      OP_IRQ:          pc_nxt = vec_sel ? ADDR_W'(VEC_HI) : ADDR_W'(VEC_LO);
      default:         pc_nxt = pc;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pc <= '0;
    else        pc <= pc_nxt;
  end

  // R2
  inc_keep_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_INC) |=> pc[MSB] == $past(pc[MSB]));
  // R2
  inc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_INC) |=> pc[MSB-1:0] == $past(ofs_inc));
  // R4
  branch_ofs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_JUMP || op == OP_CALL) |=> pc[MSB-1:0] == $past(target));
  // R6
  irq_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_IRQ) |=> (pc == ADDR_W'(VEC_LO) || pc == ADDR_W'(VEC_HI)));
endmodule

// File: rtl/pc_bank_unit.sv
module pc_bank_unit
  import pcu_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int STACK_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inc_i,
  input  logic              jump_i,
  input  logic              call_i,
  input  logic              ret_i,
  input  logic              retr_i,
  input  logic              sel_bank0_i,
  input  logic              sel_bank1_i,
  input  logic              irq_i,
  input  logic              irq_vec_i,
  input  logic [ADDR_W-2:0] target_i,
  output logic [ADDR_W-1:0] pc_o
);
  localparam int ENT_W = ADDR_W + 1;

  pc_op_e           op;
  logic             bank_ff, in_svc;
  logic             push, pop;
  logic [ENT_W-1:0] stk_top;

  assign op   = pick_op(irq_i, call_i, jump_i, retr_i, ret_i, inc_i);
  assign push = (op == OP_CALL) || (op == OP_IRQ);
  assign pop  = (op == OP_RET)  || (op == OP_RETR);

  pcu_bank_ctl u_bank (
    .clk(clk), .rst_n(rst_n), .sel0(sel_bank0_i), .sel1(sel_bank1_i),
    .enter(op == OP_IRQ), .leave(op == OP_RETR),
    .restore_svc(stk_top[ENT_W-1]), .bank_ff(bank_ff), .in_svc(in_svc)
  );

  pcu_ret_stack #(.DEPTH(STACK_DEPTH), .W(ENT_W)) u_stack (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
    .wdata({in_svc, pc_o}), .top(stk_top)
  );

  pcu_pc_reg #(.ADDR_W(ADDR_W)) u_pc (
    .clk(clk), .rst_n(rst_n), .op(op), .vec_sel(irq_vec_i),
    .target(target_i), .bank_ff(bank_ff), .in_svc(in_svc),
    .pop_addr(stk_top[ADDR_W-1:0]), .pc(pc_o)
  );

  // R7
  svc_low_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_svc |-> !pc_o[ADDR_W-1]);
  // R5
  ret_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_RET && !in_svc) |=> pc_o == $past(stk_top[ADDR_W-1:0]));
  // R8
  retr_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_RETR) |=> pc_o == $past(stk_top[ADDR_W-1:0]));
endmodule

// File: tb/pc_bank_unit_bench.sv
module pc_bank_unit_bench;
  localparam logic [8:0] C_INC = 9'h001, C_JMP = 9'h002, C_CALL = 9'h004,
                         C_RET = 9'h008, C_RETR = 9'h010, C_S0 = 9'h020,
                         C_S1  = 9'h040, C_IRQ = 9'h080;

  typedef struct packed {
    logic [3:0]  req;
    logic [8:0]  ctl;
    logic        vec;
    logic [10:0] tgt;
    logic [11:0] exp;
  } vec_t;

  localparam int NV = 29;
  localparam vec_t TBL [NV] = '{
    '{4'd2,  C_INC,                 1'b0, 11'h000, 12'h001}, // R2
    '{4'd2,  C_INC,                 1'b0, 11'h000, 12'h002}, // R2
    '{4'd3,  C_S1,                  1'b0, 11'h000, 12'h002}, // R3
    '{4'd3,  C_INC,                 1'b0, 11'h000, 12'h003}, // R3
    '{4'd4,  C_JMP,                 1'b0, 11'h7FE, 12'hFFE}, // R4
    '{4'd2,  C_INC,                 1'b0, 11'h000, 12'hFFF}, // R2
    '{4'd2,  C_INC,                 1'b0, 11'h000, 12'h800}, // R2 wrap
    '{4'd5,  C_CALL,                1'b0, 11'h010, 12'h810}, // R5
    '{4'd3,  C_S0,                  1'b0, 11'h000, 12'h810}, // R3
    '{4'd5,  C_RET,                 1'b0, 11'h000, 12'h800}, // R5
    '{4'd4,  C_JMP,                 1'b0, 11'h123, 12'h123}, // R4
    '{4'd3,  C_S1,                  1'b0, 11'h000, 12'h123}, // R3
    '{4'd6,  C_IRQ,                 1'b1, 11'h000, 12'h007}, // R6
    '{4'd7,  C_INC,                 1'b0, 11'h000, 12'h008}, // R7
    '{4'd7,  C_JMP,                 1'b0, 11'h456, 12'h456}, // R7
    '{4'd7,  C_CALL,                1'b0, 11'h100, 12'h100}, // R7
    '{4'd7,  C_S0,                  1'b0, 11'h000, 12'h100}, // R7
    '{4'd7,  C_S1,                  1'b0, 11'h000, 12'h100}, // R7
    '{4'd7,  C_RET,                 1'b0, 11'h000, 12'h456}, // R7
    '{4'd8,  C_RETR,                1'b0, 11'h000, 12'h123}, // R8
    '{4'd8,  C_JMP,                 1'b0, 11'h200, 12'hA00}, // R8
    '{4'd10, C_IRQ | C_CALL | C_JMP, 1'b0, 11'h555, 12'h003}, // R10
    '{4'd8,  C_RETR,                1'b0, 11'h000, 12'hA00}, // R8
    '{4'd10, C_CALL | C_JMP | C_INC, 1'b0, 11'h011, 12'h811}, // R10
    '{4'd10, C_RET | C_INC,         1'b0, 11'h000, 12'hA00}, // R10
    '{4'd3,  C_S0 | C_S1,           1'b0, 11'h000, 12'hA00}, // R3
    '{4'd3,  C_JMP,                 1'b0, 11'h000, 12'h800}, // R3
    '{4'd4,  C_S0 | C_JMP,          1'b0, 11'h001, 12'h801}, // R4
    '{4'd4,  C_JMP,                 1'b0, 11'h002, 12'h002}  // R4
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [8:0]  ctl = '0;
  logic        vec = 1'b0;
  logic [10:0] tgt = '0;
  logic [11:0] pc;
  int          n_chk = 0;
  int          n_bad = 0;

  always #10 clk = ~clk;

  pc_bank_unit u_pc_bank_unit (
    .clk(clk), .rst_n(rst_n), .inc_i(ctl[0]), .jump_i(ctl[1]),
    .call_i(ctl[2]), .ret_i(ctl[3]), .retr_i(ctl[4]),
    .sel_bank0_i(ctl[5]), .sel_bank1_i(ctl[6]), .irq_i(ctl[7]),
    .irq_vec_i(vec), .target_i(tgt), .pc_o(pc)
  );

  task automatic check(input string req, input logic [11:0] exp);
    n_chk++;
    if (pc !== exp) begin
      n_bad++;
      $display("FAIL %s: pc_o=%03h expected %03h", req, pc, exp);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge.
  task automatic step(input logic [8:0] c, input logic v, input logic [10:0] t);
    ctl = c; vec = v; tgt = t;
    @(negedge clk);
    ctl = '0; vec = 1'b0; tgt = '0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R1", 12'h000);
    rst_n = 1'b1;
  endtask

  initial begin
    @(negedge clk);
    do_reset();
    check("R1", 12'h000);

    for (int i = 0; i < NV; i++) begin
      step(TBL[i].ctl, TBL[i].vec, TBL[i].tgt);
      check($sformatf("R%0d row %0d", TBL[i].req, i), TBL[i].exp);
    end

    // R1: reset inside a handler with the upper half chosen
    step(C_S1, 1'b0, 11'h0);
    step(C_IRQ, 1'b0, 11'h0);
    check("R1", 12'h003);
    do_reset();
    step(C_JMP, 1'b0, 11'h007);
    check("R1", 12'h007);
    step(C_S1, 1'b0, 11'h0);
    step(C_JMP, 1'b0, 11'h001);
    check("R1", 12'h801);

    // R9: nine nested calls against an eight-entry stack
    do_reset();
    for (int k = 1; k <= 9; k++) begin
      step(C_CALL, 1'b0, 11'(16 + k));
      check("R9", 12'(16 + k));
    end
    for (int j = 1; j <= 9; j++) begin
      step(C_RET, 1'b0, 11'h0);
      check("R9", (j == 9) ? 12'h018 : 12'(16 + 9 - j));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not end, actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule